// File: doc/BRIEF.md
# Serial-Controlled Wiper Register for a 256-Tap Potentiometer

This block is the digital half of a 256-tap potentiometer. It is an I2C target that holds an 8-bit wiper code and presents that code as a tap-select bus to the resistor array. It also drives a shutdown flag. A host writes an instruction byte and, in most cases, a data byte. It can read the wiper code back at any time. The instruction byte alone can return the wiper to the centre tap or open the array into shutdown.

A fast system clock samples SCL and SDA. Each line passes through a synchronizer and a stability filter, so short spikes never reach the protocol state machine. The wiper starts at the centre code. The block ignores the bus until the power-good input has been high for a programmable settling time. The new wiper code reaches the tap bus on the SCL falling edge that ends the data byte.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: While and after reset, tap_sel is 0x80, shutdown is 0 and sda_oe is 0.
- R2: The block acknowledges only the 7-bit address 0101100 with the addr_pin value appended as bit 0, sent MSB first and followed by the R/W bit (1 = read). Any other address gets no acknowledge, and the bytes that follow leave tap_sel and shutdown unchanged.
- R3: Until pwr_good has been high for PWR_WAIT consecutive clock cycles, every address is left unacknowledged. A drop of pwr_good restarts the wait.
- R4: After an instruction byte with bits 6 and 5 both 0, the next byte is taken as the wiper code and acknowledged. tap_sel does not change while SCL is high after the eighth data bit. It takes the new code within FILT_CYC+6 cycles of that bit's SCL falling edge.
- R5: An instruction byte with bit 6 set loads tap_sel with 0x80. No data byte is expected after it, and a further byte is not acknowledged and leaves tap_sel unchanged.
- R6: An instruction byte with bit 5 set drives shutdown to 1 and leaves tap_sel unchanged. Any instruction byte with bit 5 clear drives shutdown back to 0.
- R7: A read sends the current tap_sel value MSB first, one bit per SCL low phase. After a master acknowledge the same value is sent again. After a master NACK, sda_oe stays 0 until the next START.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_CYC system cycles has no effect on the transfer in progress.
- R9: Instruction bits 7 and 4 to 0 have no effect on the outcome of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| pwr_good | input | 1 | Supply-stable indication from the power monitor |
| addr_pin | input | 1 | Selects bit 0 of the target address |
| scl_in | input | 1 | Bus clock as seen on the pin |
| sda_in | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain pull-down enable) |
| tap_sel | output | TAP_W | Tap code for the resistor switch network |
| shutdown | output | 1 | Opens the resistor array when 1 |

## Verification
A pin edge reaches the state machine two synchronizer cycles plus FILT_CYC filter cycles after it happens. The tap and shutdown registers then load one cycle later. The bench therefore checks the wiper in two places: once while SCL is still high after the last data bit, where the value must still be the old one, and once FILT_CYC+6 cycles after the falling edge. Acknowledge and read bits are sampled at the middle of the SCL high phase, which lies well beyond that latency. The power-up wait is probed with an address phase that ends before PWR_WAIT cycles have passed, and again after they have passed.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned CMD_MID_BIT = 6;
  localparam int unsigned CMD_SD_BIT  = 5;
  localparam logic [5:0]  DEV_ADDR_HI = 6'b010110;

  typedef enum logic [3:0] {
    BS_IDLE,
    BS_ADDR,
    BS_ADDR_ACK,
    BS_CMD,
    BS_CMD_ACK,
    BS_DATA,
    BS_DATA_ACK,
    BS_RD_BYTE,
    BS_RD_ACK,
    BS_RD_LOAD,
    BS_HOLD
  } bus_state_e;

  typedef struct packed {
    logic                cmd_vld;
    logic                cmd_mid;
    logic                cmd_sd;
    logic                dat_vld;
    logic [BYTE_W-1:0]   dat;
  } wiper_req_t;
endpackage

// File: rtl/dpot_deglitch.sv
module dpot_deglitch #(
  parameter int unsigned FILT_CYC = 13,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic          s1_q, s2_q, out_q, out_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    out_n = out_q;
    cnt_n = '0;
    if (s2_q != out_q) begin
      if (cnt_q == CW'(FILT_CYC - 1)) begin
        out_n = s2_q;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= IDLE_VAL;
      s2_q  <= IDLE_VAL;
      out_q <= IDLE_VAL;
      cnt_q <= '0;
    end else begin
      s1_q  <= din;
      s2_q  <= s1_q;
      out_q <= out_n;
      cnt_q <= cnt_n;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/dpot_pwr_timer.sv
module dpot_pwr_timer #(
  parameter int unsigned PWR_WAIT = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic ready
);
  localparam int unsigned CW = $clog2(PWR_WAIT + 1);

  logic          pg1_q, pg2_q, rdy_q, rdy_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    rdy_n = rdy_q;
    cnt_n = cnt_q;
    if (!pg2_q) begin
      rdy_n = 1'b0;
      cnt_n = '0;
    end else if (!rdy_q) begin
      if (cnt_q == CW'(PWR_WAIT - 1)) begin
        rdy_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg1_q <= 1'b0;
      pg2_q <= 1'b0;
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pg1_q <= pwr_good;
      pg2_q <= pg1_q;
      rdy_q <= rdy_n;
      cnt_q <= cnt_n;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/dpot_bus_fsm.sv
module dpot_bus_fsm
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              addr_pin,
  input  logic              scl,
  input  logic              sda,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              scl_fall,
  output wiper_req_t        req
);
  bus_state_e        st_q, st_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              oe_q, oe_n;
  logic              rw_q, rw_n;
  logic              more_q, more_n;
  logic              scl_q, sda_q;
  logic              scl_rise, start_evt, stop_evt, byte_full;

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_evt = scl & scl_q & sda_q & ~sda;
  assign stop_evt  = scl & scl_q & ~sda_q & sda;
  assign byte_full = (cnt_q == 4'd8);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    oe_n   = oe_q;
    rw_n   = rw_q;
    more_n = more_q;
    req    = '0;
    req.dat = sh_q;
    if (!ready) begin
      st_n = BS_IDLE;
      oe_n = 1'b0;
    end else if (start_evt) begin
      st_n  = BS_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_evt) begin
      st_n = BS_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        BS_ADDR, BS_CMD, BS_DATA: begin
          if (scl_rise && !byte_full) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            cnt_n = '0;
            if (st_q == BS_ADDR) begin
              if (sh_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_pin}) begin
                oe_n = 1'b1;
                rw_n = sh_q[0];
                st_n = BS_ADDR_ACK;
              end else begin
                st_n = BS_HOLD;
              end
            end else if (st_q == BS_CMD) begin
              oe_n        = 1'b1;
              req.cmd_vld = 1'b1;
              req.cmd_mid = sh_q[CMD_MID_BIT];
              req.cmd_sd  = sh_q[CMD_SD_BIT];
              more_n      = ~(sh_q[CMD_MID_BIT] | sh_q[CMD_SD_BIT]);
              st_n        = BS_CMD_ACK;
            end else begin
              oe_n        = 1'b1;
              req.dat_vld = 1'b1;
              st_n        = BS_DATA_ACK;
            end
          end
        end
        BS_ADDR_ACK, BS_RD_LOAD: begin
          if (scl_fall) begin
            if (rw_q) begin
              sh_n  = rd_byte;
              oe_n  = ~rd_byte[BYTE_W-1];
              cnt_n = 4'd1;
              st_n  = BS_RD_BYTE;
            end else begin
              oe_n = 1'b0;
              st_n = BS_CMD;
            end
          end
        end
        BS_CMD_ACK: begin
          if (scl_fall) begin
            oe_n = 1'b0;
            st_n = more_q ? BS_DATA : BS_HOLD;
          end
        end
        BS_DATA_ACK: begin
          if (scl_fall) begin
            oe_n = 1'b0;
            st_n = BS_HOLD;
          end
        end
        BS_RD_BYTE: begin
          if (scl_fall) begin
            if (byte_full) begin
              oe_n = 1'b0;
              st_n = BS_RD_ACK;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b1};
              oe_n  = ~sh_q[BYTE_W-2];
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        BS_RD_ACK: begin
          if (scl_rise) begin
            st_n = sda ? BS_HOLD : BS_RD_LOAD;
          end
        end
        default: begin
          oe_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BS_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      more_q <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      oe_q   <= oe_n;
      rw_q   <= rw_n;
      more_q <= more_n;
      scl_q  <= scl;
      sda_q  <= sda;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/dpot_wiper_reg.sv
module dpot_wiper_reg
  import dpot_pkg::*;
#(
  parameter int unsigned TAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wiper_req_t       req,
  output logic [TAP_W-1:0] tap,
  output logic             sd
);
  localparam logic [TAP_W-1:0] MID = TAP_W'(1) << (TAP_W - 1);

  logic [TAP_W-1:0] tap_q, tap_n;
  logic             sd_q, sd_n;
  logic             tap_en;

  always_comb begin
    tap_n  = tap_q;
    sd_n   = sd_q;
    tap_en = 1'b0;
    if (req.cmd_vld) begin
      sd_n = req.cmd_sd;
      if (req.cmd_mid) begin
        tap_n  = MID;
        tap_en = 1'b1;
      end
    end
    if (req.dat_vld) begin
      tap_n  = req.dat[BYTE_W-1 -: TAP_W];
      tap_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= MID;
      sd_q  <= 1'b0;
    end else begin
      if (tap_en) tap_q <= tap_n;
      if (req.cmd_vld) sd_q <= sd_n;
    end
  end

  assign tap = tap_q;
  assign sd  = sd_q;
endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl
  import dpot_pkg::*;
#(
  parameter int unsigned TAP_W    = 8,
  parameter int unsigned FILT_CYC = 13,
  parameter int unsigned PWR_WAIT = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             addr_pin,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [TAP_W-1:0] tap_sel,
  output logic             shutdown
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, flt_lines;
  logic               scl_flt, sda_flt, ready, scl_fall_evt;
  logic [BYTE_W-1:0]  rd_byte;
  wiper_req_t         req;

  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    dpot_deglitch #(.FILT_CYC(FILT_CYC), .IDLE_VAL(1'b1)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[1];
  assign sda_flt = flt_lines[0];

  dpot_pwr_timer #(.PWR_WAIT(PWR_WAIT)) u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_good(pwr_good),
    .ready   (ready)
  );

  if (TAP_W == BYTE_W) begin : g_rd_full
    assign rd_byte = tap_sel;
  end else begin : g_rd_pad
    assign rd_byte = {tap_sel, {(BYTE_W - TAP_W){1'b0}}};
  end

  dpot_bus_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (ready),
    .addr_pin(addr_pin),
    .scl     (scl_flt),
    .sda     (sda_flt),
    .rd_byte (rd_byte),
    .sda_oe  (sda_oe),
    .scl_fall(scl_fall_evt),
    .req     (req)
  );

  dpot_wiper_reg #(.TAP_W(TAP_W)) u_wiper (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .tap  (tap_sel),
    .sd   (shutdown)
  );
endmodule

// File: rtl/dpot_i2c_ctrl_chk.sv
module dpot_i2c_ctrl_chk #(
  parameter int unsigned TAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             scl_f,
  input logic             scl_fall,
  input logic             sda_oe,
  input logic [TAP_W-1:0] tap_sel,
  input logic             shutdown
);
  localparam logic [TAP_W-1:0] MID = TAP_W'(1) << (TAP_W - 1);

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_MIDSCALE: assert (tap_sel == MID && !shutdown && !sda_oe); // R1
    end
  end

  AST_TAP_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_sel) |-> $past(scl_fall)); // R4

  AST_SD_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shutdown) |-> $past(scl_fall)); // R6

  AST_QUIET_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !$past(ready)) |-> !sda_oe); // R3

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && !$stable(sda_oe)) |-> !scl_f); // R7
endmodule

bind dpot_i2c_ctrl dpot_i2c_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ready   (ready),
  .scl_f   (scl_flt),
  .scl_fall(scl_fall_evt),
  .sda_oe  (sda_oe),
  .tap_sel (tap_sel),
  .shutdown(shutdown)
);

// File: tb/dpot_i2c_ctrl_bench.sv
`timescale 1ns/1ps
module dpot_i2c_ctrl_bench;
  localparam int TAP_W    = 8;
  localparam int FILT_CYC = 13;
  localparam int PWR_WAIT = 2000;
  localparam int H        = 64;
  localparam logic [7:0] AW = 8'h5A;
  localparam logic [7:0] AR = 8'h5B;

  logic clk, rst_n, pwr_good, addr_pin, scl, sda_m;
  logic sda_oe, shutdown, sda_line;
  logic [TAP_W-1:0] tap_sel;
  int nchk, nfail;

  assign sda_line = sda_m & ~sda_oe;

  dpot_i2c_ctrl #(.TAP_W(TAP_W), .FILT_CYC(FILT_CYC), .PWR_WAIT(PWR_WAIT)) u_dpot_i2c_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .addr_pin(addr_pin),
    .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe), .tap_sel(tap_sel),
    .shutdown(shutdown)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; cyc(H);
    sda_m = 1'b0; cyc(H);
    scl = 1'b0; cyc(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(H/2);
    scl = 1'b1; cyc(H);
    sda_m = 1'b1; cyc(H);
  endtask

  task automatic send_bit_g(input bit b, input bit gscl, input bit gsda);
    sda_m = b; cyc(H/2);
    scl = 1'b1; cyc(H/2);
    if (gsda) begin
      sda_m = ~b; cyc(8); sda_m = b; cyc(H/2 - 8);
    end else cyc(H/2);
    scl = 1'b0;
    if (gscl) begin
      cyc(20); scl = 1'b1; cyc(8); scl = 1'b0; cyc(H/2 - 28);
    end else cyc(H/2);
  endtask

  task automatic send_bit(input bit b);
    send_bit_g(b, 1'b0, 1'b0);
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; cyc(H/2);
    scl = 1'b1; cyc(H/2);
    b = sda_line; cyc(H/2);
    scl = 1'b0; cyc(H/2);
  endtask

  task automatic write_byte(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(r);
    ack = ~r;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] v);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(r);
      v[i] = r;
    end
    send_bit(~give_ack);
  endtask

  task automatic write_cmd(input logic [7:0] ib, input bit has_d, input logic [7:0] db);
    bit a;
    bus_start();
    write_byte(AW, a);
    write_byte(ib, a);
    if (has_d) write_byte(db, a);
    bus_stop();
  endtask

  task automatic read_one(output logic [7:0] v);
    bit a;
    bus_start();
    write_byte(AR, a);
    read_byte(1'b0, v);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(tap_sel == 8'h80, "R1 tap after reset", tap_sel, 8'h80);
    chk(shutdown == 1'b0, "R1 shutdown after reset", shutdown, 0);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
  endtask

  task automatic t_power_wait();
    bit a;
    bus_start(); write_byte(AW, a); bus_stop();
    chk(a == 1'b0, "R3 no ack while pwr_good low", a, 0);
    pwr_good = 1'b1;
    cyc(4);
    bus_start(); write_byte(AW, a); bus_stop();
    chk(a == 1'b0, "R3 no ack before wait elapsed", a, 0);
    cyc(PWR_WAIT);
    bus_start(); write_byte(AW, a); bus_stop();
    chk(a == 1'b1, "R3 ack after wait elapsed", a, 1);
  endtask

  task automatic t_address();
    bit a0, a1, a2;
    bus_start();
    write_byte(8'h58, a0); write_byte(8'h00, a1); write_byte(8'h11, a2);
    bus_stop();
    chk(a0 == 1'b0, "R2 wrong address nacked", a0, 0);
    chk(tap_sel == 8'h80, "R2 wrong address no effect", tap_sel, 8'h80);
  endtask

  task automatic t_write_timing();
    bit a, r;
    logic [7:0] d = 8'h3C;
    bus_start();
    write_byte(AW, a);
    write_byte(8'h00, a);
    chk(a == 1'b1, "R4 instruction acked", a, 1);
    for (int i = 7; i >= 1; i--) send_bit(d[i]);
    sda_m = d[0]; cyc(H/2);
    scl = 1'b1; cyc(H);
    chk(tap_sel == 8'h80, "R4 tap unchanged before last fall", tap_sel, 8'h80);
    scl = 1'b0; cyc(FILT_CYC + 6);
    chk(tap_sel == d, "R4 tap updated after last fall", tap_sel, d);
    cyc(H/2 - (FILT_CYC + 6));
    recv_bit(r);
    chk(r == 1'b0, "R4 data byte acked", r, 0);
    bus_stop();
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] v1, v2;
    bus_start();
    write_byte(AR, a);
    read_byte(1'b1, v1);
    read_byte(1'b0, v2);
    chk(v1 == tap_sel, "R7 first read byte", v1, tap_sel);
    chk(v2 == tap_sel, "R7 repeated read byte", v2, tap_sel);
    cyc(H);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_ignored_bits();
    write_cmd(8'h9F, 1'b1, 8'hE1);
    chk(tap_sel == 8'hE1, "R9 other instruction bits ignored", tap_sel, 8'hE1);
    chk(shutdown == 1'b0, "R9 no shutdown from other bits", shutdown, 0);
  endtask

  task automatic t_midscale();
    bit a0, a1, a2;
    bus_start();
    write_byte(AW, a0); write_byte(8'h40, a1); write_byte(8'h07, a2);
    bus_stop();
    chk(tap_sel == 8'h80, "R5 midscale loaded", tap_sel, 8'h80);
    chk(a2 == 1'b0, "R5 extra byte nacked", a2, 0);
  endtask

  task automatic t_shutdown();
    logic [7:0] v;
    write_cmd(8'h00, 1'b1, 8'h21);
    write_cmd(8'h20, 1'b0, 8'h00);
    chk(shutdown == 1'b1, "R6 shutdown set", shutdown, 1);
    chk(tap_sel == 8'h21, "R6 tap kept in shutdown", tap_sel, 8'h21);
    read_one(v);
    chk(v == 8'h21, "R6 read in shutdown", v, 8'h21);
    write_cmd(8'h00, 1'b1, 8'h22);
    chk(shutdown == 1'b0, "R6 shutdown released", shutdown, 0);
    chk(tap_sel == 8'h22, "R6 write after release", tap_sel, 8'h22);
  endtask

  task automatic t_glitch();
    bit a, r;
    logic [7:0] d = 8'hA5;
    bus_start();
    write_byte(AW, a);
    write_byte(8'h00, a);
    for (int i = 7; i >= 0; i--) send_bit_g(d[i], i == 5, i == 2);
    recv_bit(r);
    bus_stop();
    chk(tap_sel == d, "R8 glitches filtered", tap_sel, d);
    chk(r == 1'b0, "R8 ack after glitches", r, 0);
  endtask

  initial begin
    nchk = 0; nfail = 0;
    rst_n = 1'b0; pwr_good = 1'b0; addr_pin = 1'b1; scl = 1'b1; sda_m = 1'b1;
    cyc(5);
    t_reset();
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_power_wait();
    t_address();
    t_write_timing();
    t_read();
    t_ignored_bits();
    t_midscale();
    t_shutdown();
    t_read();
    t_glitch();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule